// File: doc/BRIEF.md
# One-Pulse-Per-Second Input Validator

This block watches an external once-per-second timing pulse that an analog front end has already turned into a digital level. The input crosses into the local clock domain through a two-flop synchronizer. Edge detection follows the synchronizer. The block then measures two things in ticks of the local clock: how long each pulse stays high, and how far apart consecutive rising edges are. It reports each measurement with a one-cycle strobe.

Every measured period is compared against a programmable window with a low limit and a high limit. A period outside the window sets a failure flag. A missing edge also sets the failure flag, as soon as the running period count passes the high limit. A separate validity flag, used by output channels that fall back to a local oscillator, is granted only after two in-range periods in a row. Any failure withdraws it at once.

Top module: `pps_validator`

## Requirements
- R1: The first rising edge after reset only arms the period counter and produces no report. Each later rising edge puts the tick count since the previous rising edge on `period_cnt_o`, together with a one-cycle `period_done_o` pulse.
- R2: Each falling edge that follows a rising edge puts the number of ticks the input stayed high on `high_cnt_o`, together with a one-cycle `high_done_o` pulse.
- R3: The period count and the high-time count stop at 2^CNT_W-1 and do not wrap. The stopped value is the value that gets reported.
- R4: A period p is in range when `lim_lo_i` <= p <= `lim_hi_i`, with both bounds inclusive.
- R5: An out-of-range period sets `fail_o` and clears `valid_o` in the cycle after its `period_done_o`.
- R6: Once armed, if the running period count exceeds `lim_hi_i` before the next rising edge arrives, `fail_o` is set and `valid_o` is cleared without waiting for that edge.
- R7: An in-range period clears `fail_o`. `valid_o` is set only after two consecutive in-range periods. `valid_o` and `fail_o` are never high together.
- R8: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Measurement clock; one tick is one period of this clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pps_i | input | 1 | Asynchronous digital pulse input |
| lim_lo_i | input | CNT_W | Smallest acceptable period in ticks |
| lim_hi_i | input | CNT_W | Largest acceptable period in ticks |
| high_cnt_o | output | CNT_W | Last measured high time in ticks |
| high_done_o | output | 1 | One-cycle strobe when high_cnt_o updates |
| period_cnt_o | output | CNT_W | Last measured edge-to-edge period in ticks |
| period_done_o | output | 1 | One-cycle strobe when period_cnt_o updates |
| valid_o | output | 1 | Input judged trustworthy |
| fail_o | output | 1 | Latest check of the input failed |

## Verification
The bench drives periods of exactly the low limit and exactly the high limit, plus one tick below the low limit. A window compare that is off by one would reject a boundary period or accept the short one. It stops the input after the block has locked and checks that the failure appears before any new edge. A design that only judges at edges would stay valid forever on a dead input. It also drives a high time and a gap longer than the counter range: a wrapping counter would report a small, plausible number. Finally, it checks that validity needs two good periods after every failure, which catches a design that relocks on the first good measurement.

// File: rtl/pps_val_pkg.sv
package pps_val_pkg;
  typedef enum logic [1:0] {
    LK_NONE   = 2'd0,
    LK_ONE    = 2'd1,
    LK_LOCKED = 2'd2
  } lock_e;
endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/pps_meter.sv
module pps_meter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         level_i,
  input  logic         rise_i,
  input  logic         fall_i,
  output logic         armed_o,
  output logic [W-1:0] per_run_o,
  output logic [W-1:0] period_o,
  output logic         period_done_o,
  output logic [W-1:0] high_o,
  output logic         high_done_o
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] hi_run_q;
  logic         hi_on_q;

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] x);
    return (x == MAXV) ? x : x + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o       <= 1'b0;
      per_run_o     <= '0;
      period_o      <= '0;
      period_done_o <= 1'b0;
      hi_run_q      <= '0;
      hi_on_q       <= 1'b0;
      high_o        <= '0;
      high_done_o   <= 1'b0;
    end else begin
      period_done_o <= 1'b0;
      high_done_o   <= 1'b0;
      if (rise_i) begin
        armed_o   <= 1'b1;
        per_run_o <= {{(W-1){1'b0}}, 1'b1};
        hi_run_q  <= {{(W-1){1'b0}}, 1'b1};
        hi_on_q   <= 1'b1;
        if (armed_o) begin
          period_o      <= per_run_o;
          period_done_o <= 1'b1;
        end
      end else begin
        if (armed_o)            per_run_o <= sat_inc(per_run_o);
        if (hi_on_q && level_i) hi_run_q  <= sat_inc(hi_run_q);
      end
      if (fall_i && hi_on_q) begin
        high_o      <= hi_run_q;
        high_done_o <= 1'b1;
        hi_on_q     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pps_judge.sv
module pps_judge
  import pps_val_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         period_done_i,
  input  logic [W-1:0] period_i,
  input  logic         armed_i,
  input  logic [W-1:0] per_run_i,
  input  logic [W-1:0] lim_lo_i,
  input  logic [W-1:0] lim_hi_i,
  output logic         valid_o,
  output logic         fail_o
);
  lock_e st_q;
  logic  in_rng, tout;

  assign in_rng = (period_i >= lim_lo_i) && (period_i <= lim_hi_i);
  // late edge: declare failure before the edge shows up
  assign tout   = armed_i && (per_run_i > lim_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= LK_NONE;
      fail_o <= 1'b0;
    end else if (period_done_i) begin
      if (in_rng) begin
        fail_o <= 1'b0;
        st_q   <= (st_q == LK_NONE) ? LK_ONE : LK_LOCKED;
      end else begin
        fail_o <= 1'b1;
        st_q   <= LK_NONE;
      end
    end else if (tout) begin
      fail_o <= 1'b1;
      st_q   <= LK_NONE;
    end
  end

  assign valid_o = (st_q == LK_LOCKED);
endmodule

// File: rtl/pps_validator.sv
module pps_validator #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pps_i,
  input  logic [CNT_W-1:0] lim_lo_i,
  input  logic [CNT_W-1:0] lim_hi_i,
  output logic [CNT_W-1:0] high_cnt_o,
  output logic             high_done_o,
  output logic [CNT_W-1:0] period_cnt_o,
  output logic             period_done_o,
  output logic             valid_o,
  output logic             fail_o
);
  logic             level, rise, fall, armed;
  logic [CNT_W-1:0] per_run;

  pps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (pps_i),
    .level_o (level),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  pps_meter #(.W(CNT_W)) u_meter (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .level_i       (level),
    .rise_i        (rise),
    .fall_i        (fall),
    .armed_o       (armed),
    .per_run_o     (per_run),
    .period_o      (period_cnt_o),
    .period_done_o (period_done_o),
    .high_o        (high_cnt_o),
    .high_done_o   (high_done_o)
  );

  pps_judge #(.W(CNT_W)) u_judge (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .period_done_i (period_done_o),
    .period_i      (period_cnt_o),
    .armed_i       (armed),
    .per_run_i     (per_run),
    .lim_lo_i      (lim_lo_i),
    .lim_hi_i      (lim_hi_i),
    .valid_o       (valid_o),
    .fail_o        (fail_o)
  );
endmodule

// File: rtl/pps_val_checker.sv
module pps_val_checker #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         rise,
  input logic         armed,
  input logic [W-1:0] per_run,
  input logic [W-1:0] lim_lo_i,
  input logic [W-1:0] lim_hi_i,
  input logic [W-1:0] period_cnt_o,
  input logic         period_done_o,
  input logic         valid_o,
  input logic         fail_o
);
  localparam logic [W-1:0] MAXV = '1;

  assert_done_after_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_done_o |-> $past(rise));

  assert_no_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_run == MAXV && !rise) |=> per_run == MAXV);

  assert_out_of_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_done_o && (period_cnt_o < lim_lo_i || period_cnt_o > lim_hi_i)) |=> (fail_o && !valid_o));

  assert_late_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && per_run > lim_hi_i && !rise && !period_done_o) |=> (fail_o && !valid_o));

  assert_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !fail_o);

  assert_lock_on_report_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(period_done_o));
endmodule

bind pps_validator pps_val_checker #(.W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rise          (rise),
  .armed         (armed),
  .per_run       (per_run),
  .lim_lo_i      (lim_lo_i),
  .lim_hi_i      (lim_hi_i),
  .period_cnt_o  (period_cnt_o),
  .period_done_o (period_done_o),
  .valid_o       (valid_o),
  .fail_o        (fail_o)
);

// File: tb/sim_pps_validator.sv
`timescale 1ns/1ps
module sim_pps_validator;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;
  localparam int LO = 90;
  localparam int HI = 110;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pps = 1'b0;
  logic [W-1:0] lim_lo = W'(LO);
  logic [W-1:0] lim_hi = W'(HI);
  logic [W-1:0] high_cnt, period_cnt;
  logic         high_done, period_done, valid, fail;

  int total = 0;
  int bad = 0;
  int unsigned cyc = 0;
  int unsigned last_rise = 0;
  bit have_rise = 0;
  bit finished = 0;
  int exp_per[$];
  int exp_hi[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pps_validator #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pps_i(pps),
    .lim_lo_i(lim_lo), .lim_hi_i(lim_hi),
    .high_cnt_o(high_cnt), .high_done_o(high_done),
    .period_cnt_o(period_cnt), .period_done_o(period_done),
    .valid_o(valid), .fail_o(fail)
  );

  function automatic int sat(input int x);
    return (x > MAXV) ? MAXV : x;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver: one pulse of hi ticks high, next rise after per ticks
  task automatic pulse(input int hi, input int per);
    if (have_rise) exp_per.push_back(sat(int'(cyc - last_rise)));
    last_rise = cyc;
    have_rise = 1;
    exp_hi.push_back(sat(hi));
    pps = 1'b1;
    repeat (hi) @(negedge clk);
    pps = 1'b0;
    repeat (per - hi) @(negedge clk);
  endtask

  // monitor: scoreboard for both measurements
  always @(negedge clk) begin
    if (rst_n && period_done) begin
      if (exp_per.size() == 0) check("R1 unexpected period report", int'(period_cnt), -1);
      else check("R1/R3 period", int'(period_cnt), exp_per.pop_front());
    end
    if (rst_n && high_done) begin
      if (exp_hi.size() == 0) check("R2 unexpected high report", int'(high_cnt), -1);
      else check("R2/R3 high time", int'(high_cnt), exp_hi.pop_front());
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 valid", int'(valid), 0);
    check("R8 fail", int'(fail), 0);
    check("R8 period", int'(period_cnt), 0);
    check("R8 high", int'(high_cnt), 0);
    check("R8 strobes", int'(period_done | high_done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: first edge arms only, lock after two good periods (R7)
    pulse(25, 100);
    check("R1 no report on first edge", exp_per.size(), 0);
    check("R7 not valid before any period", int'(valid), 0);
    pulse(25, 100);
    check("R7 one good period: fail", int'(fail), 0);
    check("R7 one good period: not yet valid", int'(valid), 0);
    pulse(20, 100);
    check("R7 two good periods: valid", int'(valid), 1);

    // R4 boundaries: exactly LO and exactly HI are in range
    pulse(30, LO);
    pulse(1, HI);
    check("R4 period at low limit keeps valid", int'(valid), 1);
    pulse(25, 100);
    check("R4 period at high limit keeps valid", int'(valid), 1);
    check("R4 period at high limit no fail", int'(fail), 0);
    pulse(25, LO - 1);
    check("R5 before short period is measured", int'(valid), 1);
    pulse(25, 100);
    check("R4/R5 short period sets fail", int'(fail), 1);
    check("R4/R5 short period clears valid", int'(valid), 0);
    pulse(25, 100);
    check("R7 good period clears fail", int'(fail), 0);
    check("R7 one good after fail: not valid", int'(valid), 0);
    pulse(25, 100);
    check("R7 relock after two good", int'(valid), 1);

    // R6: input stops; failure before any new edge
    repeat (5) @(negedge clk);
    check("R6 still valid inside window", int'(valid), 1);
    repeat (25) @(negedge clk);
    check("R6 timeout sets fail", int'(fail), 1);
    check("R6 timeout clears valid", int'(valid), 0);

    // R3: long high time and long gap saturate
    pulse(300, 400);
    check("R3/R5 long gap keeps fail", int'(fail), 1);
    pulse(25, 100);
    check("R3 saturated period out of range", int'(fail), 1);
    pulse(25, 100);
    check("R7 recover: fail cleared", int'(fail), 0);
    pulse(25, 100);
    check("R7 recover: valid", int'(valid), 1);

    repeat (5) @(negedge clk);
    check("R1 all period reports seen", exp_per.size(), 0);
    check("R2 all high reports seen", exp_hi.size(), 0);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end
endmodule